// File: doc/BRIEF.md
# TRS Word Framer with Alignment Flag

This block receives a raw video bit stream delivered ten bits per clock, with no knowledge of where the word boundaries sit inside each chunk. It searches every bit offset for the timing reference sequence (one all-ones word followed by two all-zeros words). It takes the word boundary from where that sequence lies and delivers re-aligned words at a fixed pipeline delay.

Two control inputs pick one of three realignment policies. In the first, the block locks on the first sequence and never moves. In the second, it follows every sequence. In the third, an off-boundary sequence is flagged and the next sequence after that realigns the framer. A misplacement flag reports that a sequence arrived off the boundary in use. On the word that follows each sequence on that boundary, the block emits a one-clock strobe and captures the line, field and blanking bits of that word.

Top module: `trs_word_framer`

## Requirements
- R1: After reset, the aligned word, the strobe, the misplacement flag and the three captured flags are all 0, the boundary offset is 0, and the framer is unlocked.
- R2: Stream bit `10*n+i` is bit i of the chunk sampled at clock edge n. With offset k in use, word m is stream bits `10*m+k` to `10*m+k+9`, first bit in bit 0. After edge e, the aligned output holds word e-4 at the offset in use after that edge.
- R3: A sequence is word values 3FF, 000, 000 at the same offset k, for any k from 0 to 9. A sequence whose first word is word m is acted on at edge m+4. The first sequence after reset sets the offset under every policy.
- R4: With both controls low and the framer locked, a sequence at another offset leaves the offset unchanged and sets the misplacement flag. A sequence at the current offset clears the flag.
- R5: With the mode input low and the enable input high, every sequence moves the offset to its own position and clears the misplacement flag.
- R6: With the mode input high, the enable input has no effect. A sequence that arrives while the flag is set realigns the framer and clears the flag. An off-boundary sequence while the flag is clear sets the flag and leaves the offset unchanged.
- R7: A sequence that ends on the offset in use, after any realignment, raises the strobe for exactly one cycle after edge m+7, together with word m+3 on the output. A sequence that is off the boundary produces no strobe.
- R8: At each strobe, the line, field and blanking flags take bits 6, 8 and 7 respectively of the word after the sequence. They hold their values until the next strobe.
- R9: The misplacement flag changes only at an edge where a sequence is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rawIn | input | 10 | Raw stream chunk, earliest bit in bit 0 |
| frameMode | input | 1 | Policy select: high selects the flag-feedback policy |
| frameEn | input | 1 | With frameMode low: high follows every sequence |
| alignedWord | output | 10 | Re-aligned word |
| trsStrobe | output | 1 | One-cycle pulse on the word after an on-boundary sequence |
| nsp | output | 1 | Sequence seen off the boundary in use |
| hFlag | output | 1 | Captured line-blanking bit |
| vFlag | output | 1 | Captured field-blanking bit |
| fFlag | output | 1 | Captured field bit |

## Verification
The bench builds the block with its default values: a 10-bit word and the flag bits at positions 6, 7 and 8. With these values the offset space is small. The bench therefore sweeps every ordered pair of first and second offsets under all four control combinations, each run as a four-sequence pattern of first, second, second and first offsets. This covers every hold, flag, recovery and follow transition at every bit phase. Every output is compared on every cycle against a stream-level model.

// File: rtl/trs_framer_pkg.sv
package trs_framer_pkg;
  // Words in one timing reference sequence (ones, zeros, zeros).
  localparam int TRS_WORDS = 3;

  typedef struct packed {
    logic takeNew;  // move the boundary to the offset found this cycle
    logic capture;  // the word being picked follows an accepted sequence
  } fr_ctrl_t;
endpackage

// File: rtl/trs_framer_datapath.sv
module trs_framer_datapath
  import trs_framer_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int H_POS  = 6,
  parameter int V_POS  = 7,
  parameter int F_POS  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] rawIn,
  input  fr_ctrl_t          ctrl,
  output logic              trsFound,
  output logic              sameSpot,
  output logic [WORD_W-1:0] alignedWord,
  output logic              hFlag,
  output logic              vFlag,
  output logic              fFlag
);
  localparam int OFF_W = $clog2(WORD_W);
  localparam int WIN_W = (TRS_WORDS + 1) * WORD_W;

  logic [WIN_W-1:0]  window;
  logic [WORD_W-1:0] hitVec;
  logic [OFF_W-1:0]  hitOff, offReg, effOff;
  logic [WIN_W-1:0]  shifted;
  logic [WORD_W-1:0] pick;

  // Newest chunk enters at the top; the oldest sits in the low bits.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) window <= '0;
    else       window <= {rawIn, window[WIN_W-1:WORD_W]};
  end

  // One comparator per bit phase.
  generate
    for (genvar k = 0; k < WORD_W; k++) begin : g_phase
      assign hitVec[k] = (window[k +: WORD_W] == {WORD_W{1'b1}}) &&
                         (window[k+WORD_W +: WORD_W] == '0) &&
                         (window[k+2*WORD_W +: WORD_W] == '0);
    end
  endgenerate

  always_comb begin
    hitOff = '0;
    for (int k = WORD_W - 1; k >= 0; k--) begin
      if (hitVec[k]) hitOff = OFF_W'(k);
    end
  end

  assign trsFound = |hitVec;
  assign sameSpot = (hitOff == offReg);
  assign effOff   = ctrl.takeNew ? hitOff : offReg;
  assign shifted  = window >> effOff;
  assign pick     = shifted[WORD_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offReg      <= '0;
      alignedWord <= '0;
      hFlag       <= 1'b0;
      vFlag       <= 1'b0;
      fFlag       <= 1'b0;
    end else begin
      offReg      <= effOff;
      alignedWord <= pick;
      if (ctrl.capture) begin
        hFlag <= pick[H_POS];
        vFlag <= pick[V_POS];
        fFlag <= pick[F_POS];
      end
    end
  end

  // R3: the boundary only moves on a cycle with a detected sequence
  p_offset_moves_on_trs_r3: assert property (@(posedge clk) disable iff (!rstN)
    !trsFound |=> $stable(offReg));

  // R8: captured flags hold between strobes
  p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> $stable({hFlag, vFlag, fFlag}));
endmodule

// File: rtl/trs_framer_ctrl.sv
module trs_framer_ctrl
  import trs_framer_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     frameMode,
  input  logic     frameEn,
  input  logic     trsFound,
  input  logic     sameSpot,
  output fr_ctrl_t ctrl,
  output logic     nsp,
  output logic     trsStrobe
);
  logic                 locked;
  logic                 wantMove;
  logic                 accepted;
  logic [TRS_WORDS-1:0] acceptPipe;

  // Policy: unlocked always follows; otherwise feedback or enable decides.
  assign wantMove     = !locked || (frameMode ? nsp : frameEn);
  assign ctrl.takeNew = trsFound && wantMove;
  assign accepted     = trsFound && (wantMove || sameSpot);
  assign ctrl.capture = acceptPipe[TRS_WORDS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked     <= 1'b0;
      nsp        <= 1'b0;
      acceptPipe <= '0;
      trsStrobe  <= 1'b0;
    end else begin
      if (trsFound) begin
        locked <= 1'b1;
        nsp    <= !accepted;
      end
      acceptPipe <= {acceptPipe[TRS_WORDS-2:0], accepted};
      trsStrobe  <= ctrl.capture;
    end
  end

  // R9: the flag moves only on a detected sequence
  p_nsp_needs_trs_r9: assert property (@(posedge clk) disable iff (!rstN)
    !trsFound |=> $stable(nsp));

  // R4: hold policy flags an off-boundary sequence
  p_misplaced_sets_nsp_r4: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !frameMode && !frameEn && trsFound && !sameSpot) |=> nsp);

  // R5: follow policy always ends aligned
  p_follow_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!frameMode && frameEn && trsFound) |=> !nsp);

  // R6: feedback policy recovers on the next sequence
  p_feedback_recover_r6: assert property (@(posedge clk) disable iff (!rstN)
    (frameMode && nsp && trsFound) |=> !nsp);

  // R7: strobe lasts one cycle
  p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    trsStrobe |=> !trsStrobe);
endmodule

// File: rtl/trs_word_framer.sv
module trs_word_framer
  import trs_framer_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int H_POS  = 6,
  parameter int V_POS  = 7,
  parameter int F_POS  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] rawIn,
  input  logic              frameMode,
  input  logic              frameEn,
  output logic [WORD_W-1:0] alignedWord,
  output logic              trsStrobe,
  output logic              nsp,
  output logic              hFlag,
  output logic              vFlag,
  output logic              fFlag
);
  fr_ctrl_t ctrl;
  logic     trsFound;
  logic     sameSpot;

  trs_framer_datapath #(
    .WORD_W(WORD_W), .H_POS(H_POS), .V_POS(V_POS), .F_POS(F_POS)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .ctrl(ctrl),
    .trsFound(trsFound), .sameSpot(sameSpot), .alignedWord(alignedWord),
    .hFlag(hFlag), .vFlag(vFlag), .fFlag(fFlag)
  );

  trs_framer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameMode(frameMode), .frameEn(frameEn),
    .trsFound(trsFound), .sameSpot(sameSpot), .ctrl(ctrl),
    .nsp(nsp), .trsStrobe(trsStrobe)
  );
endmodule

// File: tb/trs_word_framer_bench.sv
module trs_word_framer_bench;
  localparam int W   = 10;
  localparam int NCH = 44;
  localparam int NB  = NCH * W;
  localparam int NEV = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rstN;
  logic [W-1:0] rawIn;
  logic         frameMode, frameEn;
  logic [W-1:0] alignedWord;
  logic         trsStrobe, nsp, hFlag, vFlag, fFlag;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  logic [NB-1:0] stream;
  int            evWord [NEV];
  int            evOff  [NEV];
  logic [2:0]    evHvf  [NEV];
  logic          evAcc  [NEV];
  logic          mLocked, mNsp;
  int            mOff;
  logic [2:0]    mHvf;

  trs_word_framer u_trs_word_framer (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .frameMode(frameMode),
    .frameEn(frameEn), .alignedWord(alignedWord), .trsStrobe(trsStrobe),
    .nsp(nsp), .hFlag(hFlag), .vFlag(vFlag), .fFlag(fFlag)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic buildStream(input int k1, input int k2, input int sIdx);
    for (int i = 0; i < NB; i++) stream[i] = i[0];
    for (int i = 0; i < NEV; i++) begin
      int p;
      logic [W-1:0] xyz;
      evWord[i] = 5 + 8 * i;
      evOff[i]  = (i == 0 || i == 3) ? k1 : k2;
      evHvf[i]  = 3'((i * 3 + k1 + k2 + sIdx) % 8);
      evAcc[i]  = 1'b0;
      xyz = {1'b1, evHvf[i][2], evHvf[i][1], evHvf[i][0], 6'b010100};
      p = 10 * evWord[i] + evOff[i];
      for (int j = 0; j < W; j++) stream[p + j] = 1'b1;
      for (int j = W; j < 3 * W; j++) stream[p + j] = 1'b0;
      for (int j = 0; j < W; j++) stream[p + 3 * W + j] = xyz[j];
    end
  endtask

  // Policy model written from R3..R6.
  task automatic applyEvent(input int i);
    logic take;
    if (!mLocked) begin
      mLocked = 1'b1; mOff = evOff[i]; mNsp = 1'b0; evAcc[i] = 1'b1;
    end else begin
      take = frameMode ? mNsp : frameEn;
      if (take) mOff = evOff[i];
      evAcc[i] = (evOff[i] == mOff);
      mNsp = !evAcc[i];
    end
  endtask

  task automatic runScenario(input int sel, input int k1, input int k2, input int sIdx);
    string pol;
    logic expStrobe;
    int   wIdx;
    frameMode = sel[1];
    frameEn   = sel[0];
    pol = frameMode ? "R6" : (frameEn ? "R5" : "R4");
    buildStream(k1, k2, sIdx);
    mLocked = 1'b0; mNsp = 1'b0; mOff = 0; mHvf = 3'd0;
    rstN = 1'b0; rawIn = '0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    check("R1 word", int'(alignedWord), 0);
    check("R1 strobe", int'(trsStrobe), 0);
    check("R1 nsp", int'(nsp), 0);
    check("R1 flags", int'({fFlag, vFlag, hFlag}), 0);
    for (int n = 0; n < NCH; n++) begin
      rawIn = stream[10 * n +: W];
      @(posedge clk);
      #1;
      for (int i = 0; i < NEV; i++)
        if (evWord[i] + 4 == n) applyEvent(i);
      expStrobe = 1'b0;
      for (int i = 0; i < NEV; i++)
        if (evWord[i] + 7 == n && evAcc[i]) begin
          expStrobe = 1'b1; mHvf = evHvf[i];
        end
      if (n >= 4) begin
        wIdx = 10 * (n - 4) + mOff;
        check({"R2/R3/", pol, " word"}, int'(alignedWord), int'(stream[wIdx +: W]));
      end
      check({pol, "/R9 nsp"}, int'(nsp), int'(mNsp));
      check("R7 strobe", int'(trsStrobe), int'(expStrobe));
      check("R8 flags", int'({fFlag, vFlag, hFlag}), int'(mHvf));
      @(negedge clk);
    end
  endtask

  initial begin
    int sIdx;
    rstN = 1'b0; rawIn = '0; frameMode = 1'b0; frameEn = 1'b0;
    sIdx = 0;
    @(negedge clk);
    for (int sel = 0; sel < 4; sel++)
      for (int k1 = 0; k1 < W; k1++)
        for (int k2 = 0; k2 < W; k2++) begin
          runScenario(sel, k1, k2, sIdx);
          sIdx++;
        end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule